// File: doc/BRIEF.md
# Power-Cycle Dimming Level Sequencer

This block lets a plain wall switch choose among four LED brightness settings. The user flips the switch off and back on quickly. The block sees the mains supply only as a digital line-present input. It stays powered while that input is low and counts how long the line has been gone. When the line comes back after a short gap, the brightness moves one step along a sequence that runs down and then back up. When the gap is long, the brightness returns to full.

The brightness is produced as a fixed-period PWM enable. At full brightness the enable stays high and does not pulse. The three dimmed settings give one half, one quarter and one eighth of the period high. While the line is absent the enable is forced low. Two parameters, both counted in clock cycles, set the off-time window and the PWM period. The line-present input is brought into the clock domain through a synchronizer chain before its edges are used.

Top module: `pcyc_dimmer`

## Requirements
- R1: While `rst_n` is low and right after it is released, `level_o` is 0 and `pwm_en_o` is 0. The direction after reset is downward.
- R2: The level index on `level_o` runs 0..3. While the line is present, `pwm_en_o` is high for PWM_PERIOD, PWM_PERIOD/2, PWM_PERIOD/4 or PWM_PERIOD/8 cycles of each PWM_PERIOD-cycle window, for index 0, 1, 2 or 3 in that order. At index 0 it stays high continuously.
- R3: When the line returns after an absence of at most OFF_WINDOW synchronized cycles, the index moves by exactly one in the current direction. An absence of exactly OFF_WINDOW cycles still counts as short.
- R4: Repeated short absences produce the index order 0,1,2,3,2,1,0,1,... The direction turns upward on reaching 3 and downward on reaching 0, so the index is always moving down when it sits at 0 and always moving up when it sits at 3.
- R5: When the line returns after an absence of more than OFF_WINDOW cycles, the index becomes 0 and the direction becomes downward, whatever their earlier values. The next short absence therefore gives index 1.
- R6: While the synchronized line-present signal is low, `pwm_en_o` is low.
- R7: The index changes only on the return of the line. It stays unchanged while the line is absent and while it stays present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; also the PWM and off-time timebase |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_present_i | input | 1 | Asynchronous indication that the AC line is present |
| pwm_en_o | output | 1 | PWM enable for the LED current regulator |
| level_o | output | 2 | Current brightness index, 0 = full through 3 = one eighth |

## Verification
The hardest cases to reach from the ports are the decision boundary at the end of the off window and a long-absence reset that arrives while the sequence is climbing back up. The bench drives absences of exactly OFF_WINDOW cycles and of OFF_WINDOW+1 cycles, timed in whole clock periods on the falling edge. It also walks the index to 3 and back to 2 before a long absence, so that the reset has to overwrite an upward direction. The step that follows then shows whether the direction was really restored.

// File: rtl/pcyc_dimmer_pkg.sv
package pcyc_dimmer_pkg;

   localparam int unsigned LVL_COUNT = 4;
   localparam int unsigned LVL_W     = $clog2(LVL_COUNT);

   typedef logic [LVL_W-1:0] lvl_t;

   typedef enum logic {
      DIR_DOWN = 1'b0,
      DIR_UP   = 1'b1
   } dir_e;

   localparam lvl_t LVL_FULL = '0;
   localparam lvl_t LVL_MIN  = lvl_t'(LVL_COUNT - 1);

endpackage

// File: rtl/pcyc_line_sync.sv
module pcyc_line_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_ok_o,
   output logic rise_o
);

   logic [STAGES-1:0] stg_q;
   logic              prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg_q  <= '0;
         prev_q <= 1'b0;
      end else begin
         stg_q  <= {stg_q[STAGES-2:0], line_i};
         prev_q <= stg_q[STAGES-1];
      end
   end

   assign line_ok_o = stg_q[STAGES-1];
   assign rise_o    = stg_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/pcyc_off_timer.sv
module pcyc_off_timer #(
   parameter int unsigned WINDOW = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_ok_i,
   output logic long_o
);

   localparam int unsigned SAT = WINDOW + 1;
   localparam int unsigned CW  = $clog2(SAT + 1);

   logic [CW-1:0] cnt_q;

   // Reset value is the saturated count: power-up counts as a long absence.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CW'(SAT);
      end else if (line_ok_i) begin
         cnt_q <= '0;
      end else if (cnt_q != CW'(SAT)) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign long_o = (cnt_q == CW'(SAT));

endmodule

// File: rtl/pcyc_level_seq.sv
module pcyc_level_seq
   import pcyc_dimmer_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic rise_i,
   input  logic long_i,
   output lvl_t level_o,
   output dir_e dir_o
);

   lvl_t lvl_q;
   dir_e dir_q;
   lvl_t lvl_nxt;

   always_comb begin
      lvl_nxt = (dir_q == DIR_DOWN) ? lvl_t'(lvl_q + 1'b1) : lvl_t'(lvl_q - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= LVL_FULL;
         dir_q <= DIR_DOWN;
      end else if (rise_i) begin
         if (long_i) begin
            lvl_q <= LVL_FULL;
            dir_q <= DIR_DOWN;
         end else begin
            lvl_q <= lvl_nxt;
            if (lvl_nxt == LVL_MIN) begin
               dir_q <= DIR_UP;
            end else if (lvl_nxt == LVL_FULL) begin
               dir_q <= DIR_DOWN;
            end
         end
      end
   end

   assign level_o = lvl_q;
   assign dir_o   = dir_q;

endmodule

// File: rtl/pcyc_pwm.sv
module pcyc_pwm
   import pcyc_dimmer_pkg::*;
#(
   parameter int unsigned PERIOD = 200000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enable_i,
   input  lvl_t level_i,
   output logic pwm_o
);

   localparam int unsigned PW   = $clog2(PERIOD);
   localparam bit          POW2 = (PERIOD == (1 << PW));

   logic [PW-1:0] ph_q;
   logic [PW:0]   thr;
   logic          pwm_q;

   generate
      if (POW2) begin : g_wrap
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ph_q <= '0;
            else        ph_q <= ph_q + 1'b1;
         end
      end else begin : g_cmp
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                       ph_q <= '0;
            else if (ph_q == PW'(PERIOD - 1)) ph_q <= '0;
            else                              ph_q <= ph_q + 1'b1;
         end
      end
   endgenerate

   // High-time is the period halved once per level step.
   assign thr = (PW+1)'(PERIOD) >> level_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwm_q <= 1'b0;
      else        pwm_q <= enable_i & ({1'b0, ph_q} < thr);
   end

   assign pwm_o = pwm_q;

endmodule

// File: rtl/pcyc_dimmer.sv
module pcyc_dimmer
   import pcyc_dimmer_pkg::*;
#(
   parameter int unsigned OFF_WINDOW  = 200000000,
   parameter int unsigned PWM_PERIOD  = 200000,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_present_i,
   output logic       pwm_en_o,
   output logic [1:0] level_o
);

   generate
      if (PWM_PERIOD < 8 || (PWM_PERIOD % 8) != 0) begin : g_bad_period
         $error("PWM_PERIOD must be a nonzero multiple of 8");
      end
      if (OFF_WINDOW < 1) begin : g_bad_window
         $error("OFF_WINDOW must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic line_ok;
   logic line_rise;
   logic off_long;
   lvl_t lvl;
   dir_e lvl_dir;

   pcyc_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_i    (line_present_i),
      .line_ok_o (line_ok),
      .rise_o    (line_rise)
   );

   pcyc_off_timer #(.WINDOW(OFF_WINDOW)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .line_ok_i (line_ok),
      .long_o    (off_long)
   );

   pcyc_level_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (line_rise),
      .long_i  (off_long),
      .level_o (lvl),
      .dir_o   (lvl_dir)
   );

   pcyc_pwm #(.PERIOD(PWM_PERIOD)) u_pwm (
      .clk      (clk),
      .rst_n    (rst_n),
      .enable_i (line_ok),
      .level_i  (lvl),
      .pwm_o    (pwm_en_o)
   );

   assign level_o = lvl;

endmodule

// File: rtl/pcyc_dimmer_chk.sv
module pcyc_dimmer_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       line_ok,
   input logic       line_rise,
   input logic       off_long,
   input logic       dir,
   input logic       pwm_en_o,
   input logic [1:0] level_o
);

   AST_LONG_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      line_rise && off_long |=> level_o == 2'd0 && dir == 1'b0); // R5

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      line_rise && !off_long |=> (level_o == $past(level_o) + 2'd1) || ($past(level_o) == level_o + 2'd1)); // R3

   AST_LEVEL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !line_rise |=> level_o == $past(level_o)); // R7

   AST_DARK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !line_ok |=> !pwm_en_o); // R6

   AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
      line_ok && level_o == 2'd0 |=> pwm_en_o); // R2

   AST_BOTTOM_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
      level_o == 2'd3 |-> dir == 1'b1); // R4

   AST_TOP_TURNS: assert property (@(posedge clk) disable iff (!rst_n)
      level_o == 2'd0 |-> dir == 1'b0); // R4

endmodule

bind pcyc_dimmer pcyc_dimmer_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .line_ok   (line_ok),
   .line_rise (line_rise),
   .off_long  (off_long),
   .dir       (lvl_dir),
   .pwm_en_o  (pwm_en_o),
   .level_o   (level_o)
);

// File: tb/sim_pcyc_dimmer.sv
`timescale 1ns/1ps
module sim_pcyc_dimmer;

   localparam int OFF_WIN = 100;
   localparam int PER     = 32;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line = 1'b0;
   logic       pwm;
   logic [1:0] level;

   int n_chk  = 0;
   int n_fail = 0;
   int exp_idx = 0;
   int exp_dir = 0;   // 0 = downward, 1 = upward
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   pcyc_dimmer #(.OFF_WINDOW(OFF_WIN), .PWM_PERIOD(PER), .SYNC_STAGES(2)) u0 (
      .clk            (clk),
      .rst_n          (rst_n),
      .line_present_i (line),
      .pwm_en_o       (pwm),
      .level_o        (level)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   function automatic int exp_duty(input int idx);
      return PER >> idx;
   endfunction

   task automatic measure_duty(input string req);
      int hi = 0;
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         if (pwm) hi++;
      end
      chk(req, hi, exp_duty(exp_idx));
   endtask

   // Model update on line return after k low cycles.
   task automatic model_return(input int k);
      if (k > OFF_WIN) begin
         exp_idx = 0;
         exp_dir = 0;
      end else begin
         exp_idx = (exp_dir == 0) ? exp_idx + 1 : exp_idx - 1;
         if (exp_idx == 3) exp_dir = 1;
         else if (exp_idx == 0) exp_dir = 0;
      end
   endtask

   task automatic off_on(input int k, input bit watch_dark, input string req);
      int hi = 0;
      @(negedge clk);
      line = 1'b0;
      for (int i = 0; i < k; i++) begin
         @(negedge clk);
         if (watch_dark && i >= 3) begin
            if (pwm) hi++;
            if (i == k - 1) chk("R7", int'(level), exp_idx);
         end
      end
      line = 1'b1;
      if (watch_dark) chk("R6", hi, 0);
      model_return(k);
      wait_cyc(8);
      chk(req, int'(level), exp_idx);
   endtask

   task automatic t_reset;
      rst_n = 1'b0;
      line  = 1'b0;
      wait_cyc(3);
      chk("R1", int'(level), 0);
      chk("R1", int'(pwm), 0);
      rst_n = 1'b1;
      wait_cyc(3);
      chk("R1", int'(level), 0);
      chk("R1", int'(pwm), 0);
      exp_idx = 0;
      exp_dir = 0;
   endtask

   task automatic t_power_up;
      line = 1'b1;
      wait_cyc(8);
      chk("R7", int'(level), 0);
      measure_duty("R2");
   endtask

   task automatic t_bounce;
      for (int s = 0; s < 7; s++) begin
         off_on(20, 1'b0, "R4");
         measure_duty("R2");
      end
   endtask

   task automatic t_window_edge;
      off_on(OFF_WIN, 1'b0, "R3");
      off_on(OFF_WIN + 1, 1'b0, "R5");
      chk("R5", int'(level), 0);
      off_on(10, 1'b0, "R5");
      chk("R5", int'(level), 1);
   endtask

   task automatic t_reset_while_rising;
      while (!(exp_idx == 2 && exp_dir == 1)) off_on(15, 1'b0, "R4");
      off_on(3 * OFF_WIN, 1'b0, "R5");
      measure_duty("R2");
      off_on(12, 1'b0, "R5");
      chk("R5", int'(level), 1);
   endtask

   task automatic t_dark;
      off_on(60, 1'b1, "R3");
      measure_duty("R2");
      wait_cyc(50);
      chk("R7", int'(level), exp_idx);
   endtask

   initial begin
      t_reset();
      t_power_up();
      t_bounce();
      t_window_edge();
      t_reset_while_rising();
      t_dark();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule